// File: doc/BRIEF.md
# BCD Calendar Timekeeping Register Bank

This block holds a wall-clock calendar in packed BCD: hundredths of a second, seconds, minutes, hours, a day-of-week counter, day of month, month and a two-digit year. A one-cycle pulse once per second advances the calendar. A separate sub-second pulse advances the hundredths digit pair. Software reaches the block through a plain synchronous byte port: an address, a write byte, a write strobe and a combinational read byte. A write to a time field loads that counter directly.

Three control features live inside the byte map. A stop bit sits in the top bit of the seconds byte and freezes every counter. A halt bit in the control byte freezes what software reads while the counters keep running, so that a multi-byte read stays coherent. A sticky failure flag in the flags byte records that the time source failed at some point and that the time can no longer be trusted. The serial bus front end, the oscillator, battery switchover and any century bit are outside this block.

Top module: `bcd_rtc_regs`

## Requirements
- R1: After reset the time bytes 0x00..0x07 read 00, 00, 00, 00, 01, 01, 01, 00, and the control byte 0x0C and flags byte 0x0F read 00.
- R2: A write to a time byte stores only its used bits, and the unused bits read 0. Seconds and minutes keep bits 6:0, hours and day of month keep bits 5:0, month keeps bits 4:0, weekday keeps bits 2:0 and year keeps all 8 bits. Addresses other than 0x00..0x07, 0x0C and 0x0F read 00, and writes to them change nothing; the full address is decoded, so 0x1C does not alias 0x0C.
- R3: A write to 0x00 sets the hundredths to 00 whatever the data. Each sub-second pulse advances the hundredths in BCD from 99 to 00 without carrying into seconds. A seconds pulse clears the hundredths to 00.
- R4: On a seconds pulse, seconds count 00..59 in BCD and wrap to 00 with a carry into minutes. Minutes do the same with a carry into hours. Hours wrap from 23 to 00 and carry into the day.
- R5: On each day rollover the weekday (0x04) advances by one and goes from 7 back to 1.
- R6: The day of month wraps to 01 after the last day of the month and advances the month. April, June, September and November have 30 days. February has 29 days when the year modulo 4 is 0 and 28 days otherwise. All other months have 31 days.
- R7: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R8: While bit 7 of the seconds byte (0x01) is 1, neither pulse changes any time byte.
- R9: A write to any time byte takes effect at the next clock edge. That cycle's pulses are discarded for all time bytes.
- R10: While bit 6 of 0x0C is 1, reads of 0x00..0x07 return the values held just before that bit was set, and the counters keep running. Once the bit is cleared, reads show the running values again. 0x0C reads back bit 6 only.
- R11: Bit 2 of 0x0F is set by the fail input and stays set after the input drops. Writing 0 to that bit clears it and writing 1 leaves it set. If the fail input is high in the same cycle as a clearing write, the flag stays set. The other bits of 0x0F read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| sub_tick | input | 1 | One-cycle pulse per hundredth of a second |
| osc_fail | input | 1 | Time source failure indication |
| addr | input | ADDR_W (5) | Register byte address |
| wdata | input | 8 | Write data byte |
| wr | input | 1 | Write strobe, one byte per cycle |
| rdata | output | 8 | Read data for addr, combinational |

## Verification
A wrong carry or month-length decision shows up at the ports on the very next seconds pulse. It appears as a wrong byte in the day, month, weekday or year field, so the bench sets times on or near each rollover boundary and reads the whole time block after one to three pulses. A broken snapshot path shows up as seconds that move while the halt bit is set, or as stale values once it is cleared. A lost or early failure flag shows up in the first read of the flags byte after the fail pulse or after the clearing write.

// File: rtl/rtc_pkg.sv
// Shared types and helpers for the BCD calendar register bank.
// Assumes packed-BCD digit pairs, low nibble ones, high nibble tens.
package rtc_pkg;
    localparam int NUM_TIME  = 8;
    localparam int IDX_W     = $clog2(NUM_TIME);
    localparam int BYTE_W    = 8;
    localparam logic [7:0] ADDR_CTL  = 8'h0C;
    localparam logic [7:0] ADDR_FLAG = 8'h0F;
    localparam int HALT_BIT  = 6;
    localparam int FAIL_BIT  = 2;

    typedef logic [NUM_TIME-1:0][BYTE_W-1:0] rtc_bank_t;

    // Advance a two-digit BCD value by one, no wrap handling.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'h9) bcd_inc = {v[7:4] + 4'h1, 4'h0};
        else                bcd_inc = {v[7:4], v[3:0] + 4'h1};
    endfunction
endpackage

// File: rtl/rtc_month_len.sv
// Last day of a month in BCD, from a BCD month and a BCD two-digit year.
// Leap rule: year modulo 4 equal to zero gives a 29-day February.
module rtc_month_len (
    input  logic [4:0] month,
    input  logic [7:0] year,
    output logic [5:0] last_day
);
    logic [5:0] mod_sum;
    logic       leap;

    // Year mod 4 from BCD digits: (10*t + o) mod 4 = (2*t + o) mod 4.
    always_comb begin
        mod_sum = {1'b0, year[7:4], 1'b0} + {2'b00, year[3:0]};
        leap    = (mod_sum[1:0] == 2'b00);
    end

    // Month length table.
    always_comb begin
        case (month)
            5'h02:                      last_day = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
            default:                    last_day = 6'h31;
        endcase
    end
endmodule

// File: rtl/rtc_time_core.sv
// Running calendar counters in packed BCD with a carry chain from
// seconds up to year. Assumes at most one load per cycle; a load wins
// over both pulses in that cycle. The stop bit freezes everything.
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             sub_tick,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [7:0]       load_data,
    output rtc_bank_t        bank
);
    logic [7:0] hund, yr;
    logic [6:0] sec, mins;
    logic [5:0] hr, mday;
    logic [4:0] mon;
    logic [2:0] wday;
    logic       stop;

    logic [5:0] last_day;
    logic [7:0] hund_n, sec_n, min_n, hr_n, day_n, mon_n, yr_n;
    logic       sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap;

    rtc_month_len u_len (
        .month    (mon),
        .year     (yr),
        .last_day (last_day)
    );

    // Increments and carry chain for one seconds pulse.
    always_comb begin
        hund_n   = bcd_inc(hund);
        sec_n    = bcd_inc({1'b0, sec});
        min_n    = bcd_inc({1'b0, mins});
        hr_n     = bcd_inc({2'b00, hr});
        day_n    = bcd_inc({2'b00, mday});
        mon_n    = bcd_inc({3'b000, mon});
        yr_n     = bcd_inc(yr);
        sec_wrap = (sec >= 7'h59);
        min_wrap = sec_wrap && (mins >= 7'h59);
        hr_wrap  = min_wrap && (hr >= 6'h23);
        day_wrap = hr_wrap && (mday >= last_day);
        mon_wrap = day_wrap && (mon >= 5'h12);
    end

    // Counter update: reset, then direct load, then pulses when running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hund <= 8'h00; stop <= 1'b0; sec <= 7'h00; mins <= 7'h00;
            hr <= 6'h00; wday <= 3'd1; mday <= 6'h01; mon <= 5'h01; yr <= 8'h00;
        end else if (load) begin
            case (load_idx)
                3'd0: hund <= 8'h00;
                3'd1: begin stop <= load_data[7]; sec <= load_data[6:0]; end
                3'd2: mins <= load_data[6:0];
                3'd3: hr   <= load_data[5:0];
                3'd4: wday <= load_data[2:0];
                3'd5: mday <= load_data[5:0];
                3'd6: mon  <= load_data[4:0];
                default: yr <= load_data;
            endcase
        end else if (!stop) begin
            if (sec_tick) begin
                hund <= 8'h00;
                sec  <= sec_wrap ? 7'h00 : sec_n[6:0];
                if (sec_wrap) mins <= min_wrap ? 7'h00 : min_n[6:0];
                if (min_wrap) hr   <= hr_wrap ? 6'h00 : hr_n[5:0];
                if (hr_wrap) begin
                    wday <= (wday >= 3'd7) ? 3'd1 : wday + 3'd1;
                    mday <= day_wrap ? 6'h01 : day_n[5:0];
                end
                if (day_wrap) mon <= mon_wrap ? 5'h01 : mon_n[4:0];
                if (mon_wrap) yr  <= (yr >= 8'h99) ? 8'h00 : yr_n;
            end else if (sub_tick) begin
                hund <= (hund >= 8'h99) ? 8'h00 : hund_n;
            end
        end
    end

    // Byte image of the counters in map order.
    always_comb begin
        bank[0] = hund;
        bank[1] = {stop, sec};
        bank[2] = {1'b0, mins};
        bank[3] = {2'b00, hr};
        bank[4] = {5'b00000, wday};
        bank[5] = {2'b00, mday};
        bank[6] = {3'b000, mon};
        bank[7] = yr;
    end
endmodule

// File: rtl/rtc_view.sv
// Software-visible copy of the time bytes. While halt is set the copy
// holds; otherwise it tracks the live counters every cycle.
module rtc_view
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt,
    input  rtc_bank_t live,
    output rtc_bank_t view
);
    rtc_bank_t snap;

    for (genvar i = 0; i < NUM_TIME; i++) begin : g_snap
        // Capture byte i while the halt latch is clear.
        always_ff @(posedge clk) begin
            if (!rst_n)     snap[i] <= '0;
            else if (!halt) snap[i] <= live[i];
        end
    end

    // Read source: frozen copy while halted, live otherwise.
    always_comb view = halt ? snap : live;
endmodule

// File: rtl/rtc_ctl.sv
// Halt latch and sticky failure flag. The fail input wins over a
// clearing write in the same cycle.
module rtc_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_fail,
    input  logic halt_wr,
    input  logic halt_bit,
    input  logic flag_wr,
    input  logic fail_bit,
    output logic halt_q,
    output logic fail_q
);
    // Halt latch, loaded only by a write to the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       halt_q <= 1'b0;
        else if (halt_wr) halt_q <= halt_bit;
    end

    // Failure flag: set by input, cleared only by writing zero.
    always_ff @(posedge clk) begin
        if (!rst_n) fail_q <= 1'b0;
        else        fail_q <= osc_fail | (fail_q & ~(flag_wr & ~fail_bit));
    end
endmodule

// File: rtl/bcd_rtc_regs.sv
// Top of the BCD calendar register bank: address decode, write routing
// and read multiplexing. Assumes a single-cycle write strobe and a
// combinational read of the addressed byte.
module bcd_rtc_regs
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              sub_tick,
    input  logic              osc_fail,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr,
    output logic [7:0]        rdata
);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(ADDR_CTL);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(ADDR_FLAG);
    localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'(NUM_TIME);

    rtc_bank_t live_bank, view_bank;
    logic      is_time, halt_q, fail_q;

    // Time block occupies the lowest NUM_TIME addresses.
    always_comb is_time = (addr < A_TOP);

    rtc_time_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .sub_tick  (sub_tick),
        .load      (wr && is_time),
        .load_idx  (addr[IDX_W-1:0]),
        .load_data (wdata),
        .bank      (live_bank)
    );

    rtc_view u_view (
        .clk   (clk),
        .rst_n (rst_n),
        .halt  (halt_q),
        .live  (live_bank),
        .view  (view_bank)
    );

    rtc_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_fail (osc_fail),
        .halt_wr  (wr && (addr == A_CTL)),
        .halt_bit (wdata[HALT_BIT]),
        .flag_wr  (wr && (addr == A_FLAG)),
        .fail_bit (wdata[FAIL_BIT]),
        .halt_q   (halt_q),
        .fail_q   (fail_q)
    );

    // Read multiplexer over the full address.
    always_comb begin
        rdata = 8'h00;
        if (is_time)               rdata = view_bank[addr[IDX_W-1:0]];
        else if (addr == A_CTL)    rdata[HALT_BIT] = halt_q;
        else if (addr == A_FLAG)   rdata[FAIL_BIT] = fail_q;
    end
endmodule

// File: rtl/rtc_regs_checker.sv
// Temporal checks on the BCD calendar register bank, bound to the top.
module rtc_regs_checker
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              osc_fail,
    input logic              fail_q,
    input logic              halt_q,
    input rtc_bank_t         live_bank,
    input rtc_bank_t         view_bank
);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(ADDR_CTL);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(ADDR_FLAG);
    localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'(NUM_TIME);

    assert_fail_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        osc_fail |=> fail_q);

    assert_fail_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !(wr && addr == A_FLAG && !wdata[FAIL_BIT])) |=> fail_q);

    assert_halt_freezes_view_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !(wr && addr == A_CTL)) |=> $stable(view_bank));

    assert_stop_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_bank[1][7] && !(wr && addr < A_TOP)) |=> $stable(live_bank));

    assert_sec_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(1)) |=> (live_bank[1] == $past(wdata)));

    assert_hund_write_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == '0) |=> (live_bank[0] == 8'h00));
endmodule

bind bcd_rtc_regs rtc_regs_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr),
    .addr      (addr),
    .wdata     (wdata),
    .osc_fail  (osc_fail),
    .fail_q    (fail_q),
    .halt_q    (halt_q),
    .live_bank (live_bank),
    .view_bank (view_bank)
);

// File: tb/tb_bcd_rtc_regs.sv
// Self-checking bench: directed calendar corners plus seeded random times.
module tb_bcd_rtc_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0, sub_tick = 1'b0, osc_fail = 1'b0, wr = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    int checks = 0, errors = 0;
    bit done = 1'b0;
    int m_sec, m_min, m_hr, m_wd, m_date, m_mon, m_yr;

    bcd_rtc_regs #(.ADDR_W(5)) dut (.*);

    always #4 clk = ~clk;

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int dim(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd_reg(a, v);
        chk(tag, v, exp);
    endtask

    task automatic pulse(input bit s, input bit u);
        @(negedge clk); sec_tick = s; sub_tick = u;
        @(negedge clk); sec_tick = 1'b0; sub_tick = 1'b0;
    endtask

    task automatic model_tick();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0;
                    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
                    m_date++;
                    if (m_date > dim(m_mon, m_yr)) begin
                        m_date = 1; m_mon++;
                        if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
                    end
                end
            end
        end
    endtask

    task automatic set_time(input int y, mo, d, w, h, mi, s);
        m_yr = y; m_mon = mo; m_date = d; m_wd = w; m_hr = h; m_min = mi; m_sec = s;
        wr_reg(5'h00, 8'h37);
        wr_reg(5'h01, bcd(s)); wr_reg(5'h02, bcd(mi)); wr_reg(5'h03, bcd(h));
        wr_reg(5'h04, 8'(w));  wr_reg(5'h05, bcd(d));  wr_reg(5'h06, bcd(mo));
        wr_reg(5'h07, bcd(y));
    endtask

    task automatic cmp_time(input string tag);
        rd_chk(tag, 5'h01, bcd(m_sec));  rd_chk(tag, 5'h02, bcd(m_min));
        rd_chk(tag, 5'h03, bcd(m_hr));   rd_chk(tag, 5'h04, 8'(m_wd));
        rd_chk(tag, 5'h05, bcd(m_date)); rd_chk(tag, 5'h06, bcd(m_mon));
        rd_chk(tag, 5'h07, bcd(m_yr));
    endtask

    task automatic tick_cmp(input string tag);
        pulse(1'b1, 1'b0); model_tick(); cmp_time(tag);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog (all R) actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset image
        rd_chk("R1", 5'h00, 8'h00); rd_chk("R1", 5'h01, 8'h00); rd_chk("R1", 5'h02, 8'h00);
        rd_chk("R1", 5'h03, 8'h00); rd_chk("R1", 5'h04, 8'h01); rd_chk("R1", 5'h05, 8'h01);
        rd_chk("R1", 5'h06, 8'h01); rd_chk("R1", 5'h07, 8'h00); rd_chk("R1", 5'h0C, 8'h00);
        rd_chk("R1", 5'h0F, 8'h00);

        // R2: field masks and unmapped addresses
        wr_reg(5'h02, 8'hFF); rd_chk("R2", 5'h02, 8'h7F);
        wr_reg(5'h03, 8'hFF); rd_chk("R2", 5'h03, 8'h3F);
        wr_reg(5'h04, 8'hFF); rd_chk("R2", 5'h04, 8'h07);
        wr_reg(5'h05, 8'hFF); rd_chk("R2", 5'h05, 8'h3F);
        wr_reg(5'h06, 8'hFF); rd_chk("R2", 5'h06, 8'h1F);
        wr_reg(5'h07, 8'h99); rd_chk("R2", 5'h07, 8'h99);
        wr_reg(5'h09, 8'hAA); rd_chk("R2", 5'h09, 8'h00); rd_chk("R2", 5'h02, 8'h7F);
        wr_reg(5'h1C, 8'h40); rd_chk("R2", 5'h0C, 8'h00); rd_chk("R2", 5'h1C, 8'h00);
        wr_reg(5'h1F, 8'h04); rd_chk("R2", 5'h1F, 8'h00);

        // R3: hundredths
        set_time(10, 5, 5, 3, 1, 2, 3);
        rd_chk("R3", 5'h00, 8'h00);
        repeat (3) pulse(1'b0, 1'b1);
        rd_chk("R3", 5'h00, 8'h03);
        wr_reg(5'h00, 8'h55); rd_chk("R3", 5'h00, 8'h00);
        repeat (100) pulse(1'b0, 1'b1);
        rd_chk("R3", 5'h00, 8'h00); rd_chk("R3", 5'h01, 8'h03);
        repeat (42) pulse(1'b0, 1'b1);
        rd_chk("R3", 5'h00, 8'h42);
        pulse(1'b1, 1'b0);
        rd_chk("R3", 5'h00, 8'h00); rd_chk("R3", 5'h01, 8'h04);

        // R4 R5: full time rollover and weekday wrap
        set_time(24, 3, 15, 7, 23, 59, 59);
        tick_cmp("R4");
        rd_chk("R5", 5'h04, 8'h01);
        set_time(24, 3, 15, 2, 12, 59, 59);
        tick_cmp("R4");

        // R6: month lengths and leap years
        set_time(23, 2, 28, 1, 23, 59, 59); tick_cmp("R6"); rd_chk("R6", 5'h06, 8'h03);
        set_time(24, 2, 28, 1, 23, 59, 59); tick_cmp("R6"); rd_chk("R6", 5'h05, 8'h29);
        set_time(24, 2, 29, 4, 23, 59, 59); tick_cmp("R6");
        set_time(0,  2, 28, 4, 23, 59, 59); tick_cmp("R6");
        set_time(30, 4, 30, 4, 23, 59, 59); tick_cmp("R6"); rd_chk("R6", 5'h06, 8'h05);
        set_time(30, 11, 30, 4, 23, 59, 59); tick_cmp("R6");
        set_time(30, 1, 31, 4, 23, 59, 59); tick_cmp("R6"); rd_chk("R6", 5'h06, 8'h02);

        // R7: year end and century wrap
        set_time(45, 12, 31, 6, 23, 59, 59); tick_cmp("R7"); rd_chk("R7", 5'h07, 8'h46);
        set_time(99, 12, 31, 6, 23, 59, 59); tick_cmp("R7"); rd_chk("R7", 5'h07, 8'h00);

        // R8: stop bit freezes counters
        set_time(20, 6, 6, 2, 8, 30, 45);
        repeat (5) pulse(1'b0, 1'b1);
        wr_reg(5'h01, 8'hC5);
        pulse(1'b1, 1'b0); pulse(1'b0, 1'b1);
        rd_chk("R8", 5'h01, 8'hC5); rd_chk("R8", 5'h02, 8'h30); rd_chk("R8", 5'h00, 8'h05);
        wr_reg(5'h01, 8'h45);
        pulse(1'b1, 1'b0);
        rd_chk("R8", 5'h01, 8'h46);

        // R9: write and pulse in one cycle, write wins and no carry
        @(negedge clk); addr = 5'h01; wdata = 8'h59; wr = 1'b1; sec_tick = 1'b1;
        @(negedge clk); wr = 1'b0; sec_tick = 1'b0;
        rd_chk("R9", 5'h01, 8'h59); rd_chk("R9", 5'h02, 8'h30);
        @(negedge clk); addr = 5'h02; wdata = 8'h10; wr = 1'b1; sec_tick = 1'b1;
        @(negedge clk); wr = 1'b0; sec_tick = 1'b0;
        rd_chk("R9", 5'h01, 8'h59); rd_chk("R9", 5'h02, 8'h10);

        // R10: halt freezes visible bytes while counting continues
        set_time(21, 7, 9, 5, 10, 20, 30);
        wr_reg(5'h0C, 8'hFF);
        rd_chk("R10", 5'h0C, 8'h40);
        repeat (3) begin pulse(1'b1, 1'b0); model_tick(); end
        rd_chk("R10", 5'h01, 8'h30); rd_chk("R10", 5'h02, 8'h20);
        wr_reg(5'h0C, 8'h00);
        cmp_time("R10");

        // R11: sticky failure flag
        @(negedge clk); osc_fail = 1'b1;
        @(negedge clk); osc_fail = 1'b0;
        rd_chk("R11", 5'h0F, 8'h04);
        repeat (4) @(negedge clk);
        rd_chk("R11", 5'h0F, 8'h04);
        wr_reg(5'h0F, 8'hFF); rd_chk("R11", 5'h0F, 8'h04);
        wr_reg(5'h0F, 8'h00); rd_chk("R11", 5'h0F, 8'h00);
        @(negedge clk); osc_fail = 1'b1; addr = 5'h0F; wdata = 8'h00; wr = 1'b1;
        @(negedge clk); osc_fail = 1'b0; wr = 1'b0;
        rd_chk("R11", 5'h0F, 8'h04);
        wr_reg(5'h0F, 8'h00); rd_chk("R11", 5'h0F, 8'h00);

        // R4 R6 R7: seeded random times biased toward rollover edges
        for (int it = 0; it < 40; it++) begin
            int y, mo, d, w, h, mi, s, k;
            y  = ($urandom % 3 == 0) ? 99 : int'($urandom % 100);
            mo = ($urandom % 3 == 0) ? 12 : 1 + int'($urandom % 12);
            d  = ($urandom % 2 == 0) ? dim(mo, y) : 1 + int'($urandom % dim(mo, y));
            w  = 1 + int'($urandom % 7);
            h  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
            mi = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            s  = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            k  = 1 + int'($urandom % 3);
            set_time(y, mo, d, w, h, mi, s);
            for (int t = 0; t < k; t++) begin pulse(1'b1, 1'b0); model_tick(); end
            cmp_time("R4/R6/R7 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule